// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a two-bank, 16-bit low-power SDRAM and takes the memory from power-on to a usable state. After reset it holds the clock-enable pin high and leaves the command bus at NOP while it counts down the power-up settling time. It then steps through a fixed series of commands: precharge of all banks, a set number of auto-refresh cycles, a load of the standard mode register and a load of the extended mode register. Each command is followed by its own minimum wait, and every wait cycle carries a NOP.

Both register words are fixed when the block is built. The standard word is assembled from burst length, burst type, CAS latency, operating mode and write-burst mode. The extended word carries the partial-array self-refresh, temperature and drive-strength settings. The block forces the reserved bits of both words to zero. When the extended-mode wait has passed, a ready flag rises and stays high until the next reset, so the normal traffic controller can take over the bus.

All timings are parameters in clock cycles. The default power-up count is 25000, which is 100 µs at 250 MHz.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, the command bus shows NOP at the first PWRUP_CYC rising edges, and the first other command appears at edge PWRUP_CYC+1.
- R2: `cke` is 1 during reset and at every cycle of the sequence.
- R3: The first command is precharge-all, encoded {csN,rasN,casN,weN}=4'b0010, with addr[10]=1 and every other address bit 0.
- R4: Exactly NUM_REF (default 2) auto-refresh commands follow, encoded 4'b0001. The first comes TRP_CYC edges after the precharge and each later one TRFC_CYC edges after the previous one. NOP is driven at every other edge.
- R5: The standard mode load, encoded 4'b0000 with addr[11]=0, comes TRFC_CYC edges after the last refresh.
- R6: The standard mode word has burst length in addr[2:0], burst type in addr[3], CAS latency in addr[6:4], operating mode in addr[8:7], write-burst mode in addr[9], and addr[11:10]=0.
- R7: The extended mode load uses the same encoding 4'b0000 with addr[11]=1 and addr[10:7]=0. It comes TMRD_CYC edges after the standard load.
- R8: The extended word has the self-refresh array setting in addr[2:0], the temperature setting in addr[4:3] and the drive strength in addr[6:5].
- R9: `ready` is 0 until TMRD_CYC edges after the extended load and is 1 from that edge on.
- R10: Once `ready` is 1, it stays 1 and the command bus stays at NOP until reset.
- R11: A synchronous reset applied at any point drives NOP, `cke`=1 and `ready`=0, and the whole sequence then restarts with the full power-up wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins; bit 11 selects the extended register during a mode load |
| ready | output | 1 | High once initialization has finished |

## Verification
The sequence is run three times from three starting points: a clean power-on reset, a reset applied after `ready` has risen, and a reset applied in the middle of the refresh phase. Comparing these runs shows whether reset really restarts the full wait, or whether a counter or refresh tally carries over from the run before.

At each run, every edge is compared with a timeline computed from the parameters. This catches off-by-one errors in each wait, a missing or extra refresh, and a stray command. The mode parameters use asymmetric bit patterns, so a swapped or shifted field in either register word changes the observed address.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  localparam int ADDR_W      = 12;
  localparam int PRE_ALL_BIT = 10;
  localparam int EXT_SEL_BIT = 11;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PRE  = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_MODE = 4'b0000
  } cmdCode_t;

  typedef struct packed {
    logic doPre;
    logic doRef;
    logic doMode;
    logic doExt;
    logic doReady;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PWRUP_CYC = 25000,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 20,
  parameter int TMRD_CYC  = 2,
  parameter int NUM_REF   = 2
) (
  input  logic       clk,
  input  logic       rst,
  output seqStrobe_t strobe
);

  localparam int MAX_A    = (PWRUP_CYC > TRP_CYC) ? PWRUP_CYC : TRP_CYC;
  localparam int MAX_B    = (TRFC_CYC > TMRD_CYC) ? TRFC_CYC : TMRD_CYC;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(NUM_REF + 1);

  typedef enum logic [2:0] {
    ST_PWR, ST_PRE_W, ST_REF_W, ST_MODE_W, ST_EXT_W, ST_DONE
  } seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refLeft;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    strobe = '0;
    if (cntZero) begin
      unique case (state)
        ST_PWR:    strobe.doPre   = 1'b1;
        ST_PRE_W:  strobe.doRef   = 1'b1;
        ST_REF_W:  if (refLeft != '0) strobe.doRef = 1'b1;
                   else               strobe.doMode = 1'b1;
        ST_MODE_W: strobe.doExt   = 1'b1;
        ST_EXT_W:  strobe.doReady = 1'b1;
        default:   strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PWR;
      cnt     <= CNT_W'(PWRUP_CYC);
      refLeft <= REF_W'(NUM_REF);
    end else if (strobe.doPre) begin
      state <= ST_PRE_W;
      cnt   <= CNT_W'(TRP_CYC - 1);
    end else if (strobe.doRef) begin
      state   <= ST_REF_W;
      cnt     <= CNT_W'(TRFC_CYC - 1);
      refLeft <= refLeft - 1'b1;
    end else if (strobe.doMode) begin
      state <= ST_MODE_W;
      cnt   <= CNT_W'(TMRD_CYC - 1);
    end else if (strobe.doExt) begin
      state <= ST_EXT_W;
      cnt   <= CNT_W'(TMRD_CYC - 1);
    end else if (strobe.doReady) begin
      state <= ST_DONE;
    end else if (!cntZero) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.doPre, strobe.doRef, strobe.doMode, strobe.doExt, strobe.doReady}));

  // R5
  mode_after_refs_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.doMode |-> (refLeft == '0 && $past(state) == ST_REF_W));

  // R1
  pwr_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PWR && !cntZero) |=> (strobe == '0 || state == ST_PWR));

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter logic [2:0] BURST_LEN  = 3'b011,
  parameter logic       BURST_TYPE = 1'b1,
  parameter logic [2:0] CAS_LAT    = 3'b010,
  parameter logic [1:0] OP_MODE    = 2'b00,
  parameter logic       WR_BURST   = 1'b1,
  parameter logic [2:0] EXT_PASR   = 3'b101,
  parameter logic [1:0] EXT_TEMP   = 2'b10,
  parameter logic [1:0] EXT_DRIVE  = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobe_t        strobe,
  output logic              cke,
  output cmdCode_t          cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              ready
);

  localparam logic [ADDR_W-1:0] MODE_WORD =
    {2'b00, WR_BURST, OP_MODE, CAS_LAT, BURST_TYPE, BURST_LEN};
  localparam logic [ADDR_W-1:0] EXT_WORD =
    {1'b1, 4'b0000, EXT_DRIVE, EXT_TEMP, EXT_PASR};
  localparam logic [ADDR_W-1:0] PRE_WORD = ADDR_W'(1) << PRE_ALL_BIT;

  always_ff @(posedge clk) begin
    if (rst) begin
      cke   <= 1'b1;
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      ready <= 1'b0;
    end else begin
      cke   <= 1'b1;
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      if (strobe.doPre) begin
        cmdQ  <= CMD_PRE;
        addrQ <= PRE_WORD;
      end else if (strobe.doRef) begin
        cmdQ  <= CMD_REF;
      end else if (strobe.doMode) begin
        cmdQ  <= CMD_MODE;
        addrQ <= MODE_WORD;
      end else if (strobe.doExt) begin
        cmdQ  <= CMD_MODE;
        addrQ <= EXT_WORD;
      end else if (strobe.doReady) begin
        ready <= 1'b1;
      end
    end
  end

  // R10
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && cmdQ == CMD_NOP));

  // R6
  mode_word_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.doMode |=> (cmdQ == CMD_MODE && addrQ[EXT_SEL_BIT] == 1'b0 && addrQ[10] == 1'b0));

  // R7
  ext_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    (cmdQ == CMD_MODE && addrQ[EXT_SEL_BIT]) |-> (addrQ[10:7] == 4'b0000));

  // R9
  ready_after_ext_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(strobe.doReady));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         PWRUP_CYC  = 25000,
  parameter int         TRP_CYC    = 3,
  parameter int         TRFC_CYC   = 20,
  parameter int         TMRD_CYC   = 2,
  parameter int         NUM_REF    = 2,
  parameter logic [2:0] BURST_LEN  = 3'b011,
  parameter logic       BURST_TYPE = 1'b1,
  parameter logic [2:0] CAS_LAT    = 3'b010,
  parameter logic [1:0] OP_MODE    = 2'b00,
  parameter logic       WR_BURST   = 1'b1,
  parameter logic [2:0] EXT_PASR   = 3'b101,
  parameter logic [1:0] EXT_TEMP   = 2'b10,
  parameter logic [1:0] EXT_DRIVE  = 2'b01
) (
  input  logic        clk,
  input  logic        rst,
  output logic        cke,
  output logic        csN,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic [11:0] addr,
  output logic        ready
);

  seqStrobe_t        strobe;
  cmdCode_t          cmdQ;
  logic [ADDR_W-1:0] addrQ;

  sdram_init_ctrl #(
    .PWRUP_CYC(PWRUP_CYC), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC),
    .TMRD_CYC(TMRD_CYC), .NUM_REF(NUM_REF)
  ) ctrl (
    .clk(clk), .rst(rst), .strobe(strobe)
  );

  sdram_init_dp #(
    .BURST_LEN(BURST_LEN), .BURST_TYPE(BURST_TYPE), .CAS_LAT(CAS_LAT),
    .OP_MODE(OP_MODE), .WR_BURST(WR_BURST), .EXT_PASR(EXT_PASR),
    .EXT_TEMP(EXT_TEMP), .EXT_DRIVE(EXT_DRIVE)
  ) dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cke(cke),
    .cmdQ(cmdQ), .addrQ(addrQ), .ready(ready)
  );

  assign {csN, rasN, casN, weN} = cmdQ;
  assign addr = addrQ;

endmodule

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int PW   = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 7;
  localparam int TMRD = 2;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] MRS = 4'b0000;

  // Expected words from the field layouts in R6 and R8
  localparam logic [11:0] MODE_EXP = 12'h22B;
  localparam logic [11:0] EXT_EXP  = 12'h835;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke, csN, rasN, casN, weN, ready;
  logic [11:0] addr;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  sdram_init_seq #(
    .PWRUP_CYC(PW), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD), .NUM_REF(2),
    .BURST_LEN(3'b011), .BURST_TYPE(1'b1), .CAS_LAT(3'b010), .OP_MODE(2'b00),
    .WR_BURST(1'b1), .EXT_PASR(3'b101), .EXT_TEMP(2'b10), .EXT_DRIVE(2'b01)
  ) dut (
    .clk(clk), .rst(rst), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addr(addr), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // R11: reset state, held for a few cycles
  task automatic applyReset(input string label);
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({csN, rasN, casN, weN} == NOP, "R11", {label, " cmd in reset"},
          int'({csN, rasN, casN, weN}), int'(NOP));
    check(cke == 1'b1, "R11", {label, " cke in reset"}, int'(cke), 1);
    check(ready == 1'b0, "R11", {label, " ready in reset"}, int'(ready), 0);
    rst = 1'b0;
  endtask

  // R1..R10: full timeline after reset release
  task automatic runInit(input string label);
    int pre  = PW + 1;
    int ref1 = pre + TRP;
    int ref2 = ref1 + TRFC;
    int mrs  = ref2 + TRFC;
    int ext  = mrs + TMRD;
    int rdy  = ext + TMRD;
    int badWait = 0, badCke = 0, badGap = 0, badEarly = 0, badLate = 0;
    logic [3:0] c;
    for (int n = 1; n <= rdy + 20; n++) begin
      @(posedge clk);
      @(negedge clk);
      c = {csN, rasN, casN, weN};
      if (cke !== 1'b1) badCke++;
      if (n < pre) begin
        if (c != NOP) badWait++;
      end else if (n == pre) begin
        check(c == PRE, "R1", {label, " first command is at edge PWRUP+1"}, int'(c), int'(PRE));
        check(addr == 12'h400, "R3", {label, " precharge-all address"}, int'(addr), 12'h400);
      end else if (n == ref1 || n == ref2) begin
        check(c == REF, "R4", {label, " refresh slot"}, int'(c), int'(REF));
      end else if (n == mrs) begin
        check(c == MRS, "R5", {label, " mode load slot"}, int'(c), int'(MRS));
        check(addr == MODE_EXP, "R6", {label, " mode word"}, int'(addr), int'(MODE_EXP));
      end else if (n == ext) begin
        check(c == MRS, "R7", {label, " ext load slot"}, int'(c), int'(MRS));
        check(addr == EXT_EXP, "R8", {label, " ext word"}, int'(addr), int'(EXT_EXP));
      end else if (n < rdy) begin
        if (c != NOP) badGap++;
      end else begin
        if (c != NOP || ready !== 1'b1) badLate++;
      end
      if (n < rdy && ready !== 1'b0) badEarly++;
      if (n == rdy)
        check(ready == 1'b1, "R9", {label, " ready rise"}, int'(ready), 1);
    end
    check(badWait == 0, "R1", {label, " non-NOP during power-up wait"}, badWait, 0);
    check(badCke == 0, "R2", {label, " cke low cycles"}, badCke, 0);
    check(badGap == 0, "R4", {label, " stray commands in waits"}, badGap, 0);
    check(badEarly == 0, "R9", {label, " early ready cycles"}, badEarly, 0);
    check(badLate == 0, "R10", {label, " ready/NOP broken after done"}, badLate, 0);
  endtask

  // R11: reset in the middle of the refresh phase
  task automatic midReset();
    repeat (PW + TRP + 4) @(posedge clk);
    applyReset("mid-refresh");
    runInit("after mid reset");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    applyReset("power-on");
    runInit("first run");
    applyReset("after ready");
    runInit("second run");
    applyReset("before mid");
    midReset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule